// File: doc/BRIEF.md
# Single-Word SDRAM Access Controller

This block turns single-word host requests into SDR SDRAM command sequences. A host presents a 22-bit word address, a write flag and 32-bit write data on a valid/ready port. The controller splits the address into bank, row and column and runs one closed-page cycle per request: open the row, issue one read or write, then close the bank again. Every access is exactly one word. No burst and no open-page reuse is attempted. Read data comes back with a one-cycle strobe.

All device timing limits are enforced by small down-counters: the delay from activate to column command, write recovery, precharge recovery, row cycle and minimum row-active time. The read column latency is fixed at two cycles. An external refresh timer pulses a request input. The controller remembers the request and inserts an AUTO REFRESH only when no access is in flight. It does this before it takes the next host request.

Top module: `sdram_word_ctrl`

## Requirements
- R1: Host address bits [7:0] are the column, [19:8] the row and [21:20] the bank. On ACTIVE, sd_a_o carries the row and sd_ba_o the bank. On READ and WRITE, sd_a_o[7:0] carries the column, sd_a_o[10] is 0 (no auto-precharge) and sd_ba_o carries the bank.
- R2: host_rdata_o is the value on sd_dq_i at the clock edge that ends the second cycle after the READ cycle. host_rvalid_o is high in the cycle after that edge, which is 3 cycles after the READ cycle.
- R3: A READ or WRITE comes at least 2 cycles after the ACTIVE of its bank.
- R4: A PRECHARGE comes at least 2 cycles after a WRITE.
- R5: A PRECHARGE comes at least 4 cycles after ACTIVE.
- R6: An ACTIVE or AUTO REFRESH comes at least 2 cycles after a PRECHARGE.
- R7: Two row commands (ACTIVE or AUTO REFRESH) are at least 7 cycles apart. Any command after an AUTO REFRESH comes at least 7 cycles later.
- R8: Each accepted request produces exactly one ACTIVE, then one READ or WRITE, then one PRECHARGE. sd_dq_oe_o is high only in the WRITE cycle, and sd_dq_o then holds the request's write data.
- R9: host_ready_o is high when idle with no refresh pending. It drops in the cycle after a request is accepted and stays low until that access has precharged.
- R10: Each read gives exactly one one-cycle host_rvalid_o pulse. A write gives none.
- R11: A ref_req_i pulse while idle makes host_ready_o low in the next cycle, and AUTO REFRESH is issued before the next ACTIVE. A pulse during an access gives an AUTO REFRESH after that access's PRECHARGE.
- R12: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001. After reset the controller shows NOP, host_ready_o=1 and host_rvalid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_valid_i | input | 1 | Host request valid |
| host_ready_o | output | 1 | Controller can accept a request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 22 | Word address {bank, row, column} |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data |
| host_rvalid_o | output | 1 | Read data strobe, one cycle |
| ref_req_i | input | 1 | Refresh request pulse from external timer |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank select |
| sd_a_o | output | 12 | Multiplexed row/column address |
| sd_dq_o | output | 32 | Write data to memory |
| sd_dq_oe_o | output | 1 | Data bus drive enable |
| sd_dq_i | input | 32 | Read data from memory |

## Verification
Shadow counters in the top module let the assertions check every command against each spacing rule (R3 to R7) on every cycle. The assertions also check on every cycle that ready drops after acceptance, that the read strobe is a single cycle, and that it follows a READ by exactly three cycles. The bench's scenarios are the only place where three further behaviours show: data integrity across banks and rows, correct address field placement, and the ordering of refresh against host traffic, both idle and mid-access. A small behavioural memory model serves the bench for these.

// File: rtl/sdram_word_pkg.sv
package sdram_word_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REF, ST_ACT, ST_RCD, ST_CAS, ST_WREC, ST_PRE
  } state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_dcnt.sv
module sdram_dcnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned ADDR_W = COL_W + ROW_W + BANK_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o
);
  assign col_o  = addr_i[COL_W-1:0];
  assign row_o  = addr_i[COL_W +: ROW_W];
  assign bank_o = addr_i[COL_W+ROW_W +: BANK_W];
endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc import sdram_word_pkg::*; #(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BANK_W = 2
) (
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o
);
  logic [3:0] pins;

  always_comb begin
    pins = 4'b0111;
    ba_o = '0;
    a_o  = '0;
    unique case (cmd_i)
      CMD_ACT: begin pins = 4'b0011; ba_o = bank_i; a_o = row_i; end
      CMD_RD:  begin pins = 4'b0101; ba_o = bank_i; a_o[COL_W-1:0] = col_i; end
      CMD_WR:  begin pins = 4'b0100; ba_o = bank_i; a_o[COL_W-1:0] = col_i; end
      CMD_PRE: begin pins = 4'b0010; ba_o = bank_i; end
      CMD_REF: pins = 4'b0001;
      default: pins = 4'b0111;
    endcase
  end

  assign {cs_no, ras_no, cas_no, we_no} = pins;
endmodule

// File: rtl/sdram_word_fsm.sv
module sdram_word_fsm import sdram_word_pkg::*; #(
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_WR    = 2,
  parameter int unsigned CAS_LAT = 2,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_valid_i,
  input  logic             host_we_i,
  input  logic             ref_req_i,
  input  logic             rc_zero_i,
  input  logic             rp_zero_i,
  input  logic             ras_zero_i,
  input  logic             step_zero_i,
  output logic             host_ready_o,
  output logic             accept_o,
  output cmd_e             cmd_o,
  output logic             load_rc_o,
  output logic             load_ras_o,
  output logic             load_rp_o,
  output logic             load_step_o,
  output logic [CNT_W-1:0] step_val_o,
  output logic             capture_o
);
  state_e state_q, state_d;
  logic   we_q;
  logic   ref_pend_q;
  logic   ref_done;

  assign host_ready_o = (state_q == ST_IDLE) && !ref_pend_q;
  assign accept_o     = host_ready_o && host_valid_i;

  always_comb begin
    state_d     = state_q;
    cmd_o       = CMD_NOP;
    load_rc_o   = 1'b0;
    load_ras_o  = 1'b0;
    load_rp_o   = 1'b0;
    load_step_o = 1'b0;
    step_val_o  = '0;
    capture_o   = 1'b0;
    ref_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_q)        state_d = ST_REF;
        else if (host_valid_i) state_d = ST_ACT;
      end
      ST_REF: if (rc_zero_i && rp_zero_i) begin
        cmd_o     = CMD_REF;
        load_rc_o = 1'b1;
        ref_done  = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_ACT: if (rc_zero_i && rp_zero_i) begin
        cmd_o       = CMD_ACT;
        load_rc_o   = 1'b1;
        load_ras_o  = 1'b1;
        load_step_o = 1'b1;
        step_val_o  = CNT_W'(T_RCD - 1);
        state_d     = ST_RCD;
      end
      ST_RCD: if (step_zero_i) begin
        load_step_o = 1'b1;
        if (we_q) begin
          cmd_o      = CMD_WR;
          step_val_o = CNT_W'(T_WR - 1);
          state_d    = ST_WREC;
        end else begin
          cmd_o      = CMD_RD;
          step_val_o = CNT_W'(CAS_LAT - 1);
          state_d    = ST_CAS;
        end
      end
      ST_CAS: if (step_zero_i) begin
        capture_o = 1'b1;
        state_d   = ST_PRE;
      end
      ST_WREC: if (step_zero_i) state_d = ST_PRE;
      ST_PRE: if (ras_zero_i) begin
        cmd_o     = CMD_PRE;
        load_rp_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      we_q       <= 1'b0;
      ref_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) we_q <= host_we_i;
      // a new request outranks the clear of the one just served
      if (ref_req_i)     ref_pend_q <= 1'b1;
      else if (ref_done) ref_pend_q <= 1'b0;
    end
  end

  AST_REF_BEFORE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_i && state_q == ST_IDLE |=> !host_ready_o); // R11
endmodule

// File: rtl/sdram_word_ctrl.sv
module sdram_word_ctrl import sdram_word_pkg::*; #(
  parameter int unsigned COL_W   = 8,
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_RP    = 2,
  parameter int unsigned T_WR    = 2,
  parameter int unsigned T_RC    = 7,
  parameter int unsigned T_RAS   = 4,
  parameter int unsigned CAS_LAT = 2,
  localparam int unsigned ADDR_W = COL_W + ROW_W + BANK_W,
  localparam int unsigned T_MAX  = max2(max2(max2(T_RCD, T_RP), max2(T_WR, T_RC)),
                                        max2(T_RAS, CAS_LAT)),
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  output logic              host_ready_o,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  input  logic              ref_req_i,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ROW_W-1:0]  sd_a_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);
  cmd_e              cmd_w;
  logic              accept;
  logic              load_rc, load_ras, load_rp, load_step, capture;
  logic              rc_zero, ras_zero, rp_zero, step_zero;
  logic [CNT_W-1:0]  step_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [BANK_W-1:0] bank;

  sdram_word_fsm #(
    .T_RCD(T_RCD), .T_WR(T_WR), .CAS_LAT(CAS_LAT), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .host_valid_i, .host_we_i, .ref_req_i,
    .rc_zero_i(rc_zero), .rp_zero_i(rp_zero), .ras_zero_i(ras_zero), .step_zero_i(step_zero),
    .host_ready_o, .accept_o(accept), .cmd_o(cmd_w),
    .load_rc_o(load_rc), .load_ras_o(load_ras), .load_rp_o(load_rp),
    .load_step_o(load_step), .step_val_o(step_val), .capture_o(capture)
  );

  sdram_dcnt #(.W(CNT_W)) u_rc_cnt (
    .clk_i, .rst_ni, .load_i(load_rc), .load_val_i(CNT_W'(T_RC - 1)), .zero_o(rc_zero));
  sdram_dcnt #(.W(CNT_W)) u_ras_cnt (
    .clk_i, .rst_ni, .load_i(load_ras), .load_val_i(CNT_W'(T_RAS - 1)), .zero_o(ras_zero));
  sdram_dcnt #(.W(CNT_W)) u_rp_cnt (
    .clk_i, .rst_ni, .load_i(load_rp), .load_val_i(CNT_W'(T_RP - 1)), .zero_o(rp_zero));
  sdram_dcnt #(.W(CNT_W)) u_step_cnt (
    .clk_i, .rst_ni, .load_i(load_step), .load_val_i(step_val), .zero_o(step_zero));

  sdram_addr_split #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_split (
    .addr_i(addr_q), .col_o(col), .row_o(row), .bank_o(bank));

  sdram_cmd_enc #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_enc (
    .cmd_i(cmd_w), .bank_i(bank), .row_i(row), .col_i(col),
    .cs_no(sd_cs_no), .ras_no(sd_ras_no), .cas_no(sd_cas_no), .we_no(sd_we_no),
    .ba_o(sd_ba_o), .a_o(sd_a_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= host_addr_i;
        wdata_q <= host_wdata_i;
      end
      if (capture) rdata_q <= sd_dq_i;
      rvalid_q <= capture;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
  assign sd_dq_o       = wdata_q;
  assign sd_dq_oe_o    = (cmd_w == CMD_WR);

  // shadow spacing counters, saturating, used only by the checks below
  logic [7:0] since_act, since_pre, since_wr, since_ref, since_row;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '1; since_pre <= '1; since_wr <= '1; since_ref <= '1; since_row <= '1;
    end else begin
      since_act <= (cmd_w == CMD_ACT) ? 8'd1 : (since_act == '1 ? since_act : since_act + 8'd1);
      since_pre <= (cmd_w == CMD_PRE) ? 8'd1 : (since_pre == '1 ? since_pre : since_pre + 8'd1);
      since_wr  <= (cmd_w == CMD_WR)  ? 8'd1 : (since_wr  == '1 ? since_wr  : since_wr  + 8'd1);
      since_ref <= (cmd_w == CMD_REF) ? 8'd1 : (since_ref == '1 ? since_ref : since_ref + 8'd1);
      since_row <= (cmd_w == CMD_ACT || cmd_w == CMD_REF) ? 8'd1
                 : (since_row == '1 ? since_row : since_row + 8'd1);
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w == CMD_RD || cmd_w == CMD_WR) |-> since_act >= 8'(T_RCD)); // R3
  AST_WR_REC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_w == CMD_PRE |-> since_wr >= 8'(T_WR)); // R4
  AST_RAS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_w == CMD_PRE |-> since_act >= 8'(T_RAS)); // R5
  AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w == CMD_ACT || cmd_w == CMD_REF) |-> since_pre >= 8'(T_RP)); // R6
  AST_RC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w == CMD_ACT || cmd_w == CMD_REF) |-> since_row >= 8'(T_RC)); // R7
  AST_REF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_w != CMD_NOP |-> since_ref >= 8'(T_RC)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_i && host_ready_o |=> !host_ready_o); // R9
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |=> !host_rvalid_o); // R10
  AST_CAS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rvalid_o) |-> $past(cmd_w == CMD_RD, 3)); // R2
endmodule

// File: tb/sdram_word_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_word_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0, ref_req = 1'b0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, rvalid;
  logic [31:0] rdata;
  logic        cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [1:0]  ba;
  logic [11:0] a;
  logic [31:0] dq_o;
  logic [31:0] dq_i = '0;

  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_word_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_valid_i(valid), .host_ready_o(ready), .host_we_i(we),
    .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_rvalid_o(rvalid), .ref_req_i(ref_req),
    .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n),
    .sd_ba_o(ba), .sd_a_o(a), .sd_dq_o(dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_i));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory model and command monitor
  logic [31:0] mem [logic [21:0]];
  logic [11:0] open_row [4];
  logic [21:0] cur_addr = '0;
  logic [31:0] cur_wdata = '0;
  int t_act = -1000, t_pre = -1000, t_wr = -1000, t_ref = -1000, t_row = -1000, t_rd = -1000;
  int n_act = 0, n_rw = 0, n_pre = 0, n_ref = 0, n_rv = 0, order_bad = 0;
  logic [31:0] last_rdata = '0;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] code;
    code = {cs_n, ras_n, cas_n, we_n};
    if (code != 4'b0100) chk(dq_oe == 1'b0, "R8 oe", dq_oe, 0);
    if (code != 4'b0111) chk(cyc - t_ref >= 7, "R7 after-ref", cyc - t_ref, 7);
    case (code)
      4'b0111: ;
      4'b0011: begin
        chk(cyc - t_pre >= 2, "R6", cyc - t_pre, 2);
        chk(cyc - t_row >= 7, "R7", cyc - t_row, 7);
        chk({ba, a} == cur_addr[21:8], "R1 act", {ba, a}, cur_addr[21:8]);
        if (n_act != 0 || n_rw != 0 || n_pre != 0) order_bad++;
        open_row[ba] = a;
        t_act = cyc; t_row = cyc; n_act++;
      end
      4'b0101, 4'b0100: begin
        logic [21:0] key;
        chk(cyc - t_act >= 2, "R3", cyc - t_act, 2);
        chk(a[7:0] == cur_addr[7:0] && a[10] == 1'b0 && ba == cur_addr[21:20],
            "R1 col", {ba, a}, {cur_addr[21:20], 4'h0, cur_addr[7:0]});
        if (n_act != 1 || n_rw != 0) order_bad++;
        key = {ba, open_row[ba], a[7:0]};
        n_rw++;
        if (code == 4'b0100) begin
          chk(dq_oe && dq_o == cur_wdata, "R8 wdata", dq_o, cur_wdata);
          mem[key] = dq_o;
          t_wr = cyc;
        end else begin
          t_rd = cyc;
          fork
            begin
              automatic logic [31:0] v = mem.exists(key) ? mem[key] : 32'hDEAD_BEEF;
              @(posedge clk); @(posedge clk); #1 dq_i = v;
            end
          join_none
        end
      end
      4'b0010: begin
        chk(cyc - t_act >= 4, "R5", cyc - t_act, 4);
        chk(cyc - t_wr >= 2, "R4", cyc - t_wr, 2);
        if (n_rw != 1) order_bad++;
        t_pre = cyc; n_pre++;
      end
      4'b0001: begin
        chk(cyc - t_pre >= 2, "R6 ref", cyc - t_pre, 2);
        chk(cyc - t_row >= 7, "R7 ref", cyc - t_row, 7);
        t_ref = cyc; t_row = cyc; n_ref++;
      end
      default: chk(1'b0, "R12 code", code, 4'b0111);
    endcase
    if (rvalid) begin
      chk(cyc - t_rd == 3, "R2 lat", cyc - t_rd, 3);
      last_rdata = rdata;
      n_rv++;
    end
  end

  bit accepted = 0;

  task automatic do_op(input logic w, input logic [21:0] ad, input logic [31:0] d, input string tag);
    int guard;
    @(negedge clk); #1;
    valid = 1'b1; we = w; addr = ad; wdata = d;
    cur_addr = ad; cur_wdata = d;
    n_act = 0; n_rw = 0; n_pre = 0; n_rv = 0; order_bad = 0; accepted = 0;
    guard = 0;
    while (!ready && guard < 100) begin @(negedge clk); #1; guard++; end
    @(negedge clk); #1;
    valid = 1'b0; accepted = 1;
    chk(ready == 1'b0, "R9 busy", ready, 0);
    guard = 0;
    while (n_pre == 0 && guard < 100) begin @(negedge clk); #1; guard++; end
    repeat (4) begin @(negedge clk); #1; end
    chk(n_act == 1 && n_rw == 1 && n_pre == 1 && order_bad == 0, {"R8 seq ", tag},
        {n_act[7:0], n_rw[7:0], n_pre[7:0], order_bad[7:0]}, 32'h01010100);
    if (w) chk(n_rv == 0, {"R10 wr ", tag}, n_rv, 0);
    else begin
      chk(n_rv == 1, {"R10 rd ", tag}, n_rv, 1);
      chk(last_rdata == d, {"R2 data ", tag}, last_rdata, d);
    end
  endtask

  // {we, addr, data}; for reads data is the expected value
  localparam logic [54:0] VEC [11] = '{
    {1'b1, 22'h000000, 32'h1111_0001},
    {1'b1, 22'h1ABC12, 32'hA5A5_5A5A},
    {1'b0, 22'h000000, 32'h1111_0001},
    {1'b1, 22'h2000FF, 32'h0F0F_F0F0},
    {1'b0, 22'h1ABC12, 32'hA5A5_5A5A},
    {1'b1, 22'h3FFFFF, 32'hFFFF_FFFF},
    {1'b1, 22'h000100, 32'h2222_0002},
    {1'b0, 22'h3FFFFF, 32'hFFFF_FFFF},
    {1'b0, 22'h000100, 32'h2222_0002},
    {1'b0, 22'h000000, 32'h1111_0001},
    {1'b0, 22'h2000FF, 32'h0F0F_F0F0}
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1 && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && rvalid == 1'b0,
        "R12 reset", {ready, cs_n, ras_n, cas_n, we_n, rvalid}, 6'b101110);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready == 1'b1 && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9 idle ready",
        {ready, cs_n, ras_n, cas_n, we_n}, 5'b10111);

    for (int i = 0; i < 11; i++)
      do_op(VEC[i][54], VEC[i][53:32], VEC[i][31:0], $sformatf("vec%0d", i));

    // R11: refresh while idle wins over the next request
    begin
      int refs0;
      refs0 = n_ref;
      @(negedge clk); #1 ref_req = 1'b1;
      @(negedge clk); #1 ref_req = 1'b0;
      chk(ready == 1'b0, "R11 idle hold", ready, 0);
      do_op(1'b0, 22'h1ABC12, 32'hA5A5_5A5A, "ref-idle");
      chk(n_ref == refs0 + 1 && t_ref < t_act, "R11 idle order", t_ref, t_act);
    end

    // R11: refresh requested mid-access lands after that access precharges
    begin
      int refs0, pre_at, guard;
      refs0 = n_ref;
      fork
        do_op(1'b1, 22'h155555, 32'h5555_AAAA, "ref-mid");
        begin
          wait (accepted);
          @(negedge clk); #1 ref_req = 1'b1;
          @(negedge clk); #1 ref_req = 1'b0;
        end
      join
      pre_at = t_pre;
      guard = 0;
      while (n_ref == refs0 && guard < 50) begin @(negedge clk); #1; guard++; end
      chk(n_ref == refs0 + 1 && t_ref > pre_at, "R11 mid order", t_ref, pre_at);
      do_op(1'b0, 22'h155555, 32'h5555_AAAA, "after-ref");
      chk(t_act > t_ref, "R11 act after ref", t_act, t_ref);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule